// File: doc/BRIEF.md
# Activity monitor counter bank

The block keeps a per-core set of free-running 64-bit counters for power and performance management. Four fixed counters track core clock ticks, constant-rate reference ticks, retired instructions and dispatch stall cycles caused by last-level cache misses. A second group holds a parameterised number (0 to 16) of auxiliary counters, each fed by its own event pulse. While the core sits in a wait-for-interrupt or wait-for-event state, no counter advances. A higher-privilege agent sets one enable bit per group. A disabled group does not count and reads as zero.

Software reaches the counters through a register-style request port. Each request carries a group select, a 4-bit index, a write flag with data, the requester's privilege level and a guest flag. A request is taken in any cycle in which `req_valid` is high. The port has no ready signal, so a requester never waits. Exactly one cycle later `rsp_valid` pulses with the read data and the fault flags. A response cannot be held back and must be consumed when it appears. Guest accesses get an undefined-access response. Lowest-level accesses trap unless the user-access control bit allows reads. Writes exist so that counters can be saved and restored across core power-off.

Top module: `actmon_bank`

## Requirements
- R1: Fixed counter at index 0 counts `core_tick`, 1 counts `ref_tick`, 2 counts `inst_ret`, 3 counts `llc_stall`. Each advances by one on every clock edge where its event is high, `arch_en` is 1 and `wait_state` is 0.
- R2: Auxiliary counter n (group select 1, index n < AUX_N) advances by one on every edge where `aux_ev[n]` is high, `aux_en` is 1 and `wait_state` is 0.
- R3: While `wait_state` is 1, no counter changes except by an accepted write.
- R4: After reset every counter reads zero, and `rsp_valid` stays low until the first request.
- R5: While a group's enable is 0, reads of that group return zero and its counters do not count. Accepted writes still load the counter, and the stored value reads back once the enable returns to 1.
- R6: A request with `req_guest`=1 responds with `rsp_undef`=1, `rsp_trap`=0 and data zero, and changes no counter.
- R7: A non-guest request at privilege 0 responds with `rsp_trap`=1 and data zero, and changes nothing, when `user_acc_en` is 0 or the request is a write. A privilege-0 read with `user_acc_en`=1 succeeds.
- R8: A non-guest write at privilege 1 or higher loads `req_wdata` into the addressed counter. In the same cycle it takes priority over an increment of that counter.
- R9: Fixed-group indices 4 to 15 and auxiliary indices at or above AUX_N read zero, and writes to them are ignored. Such an index does not alias a real counter.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Read data is the counter value in the request cycle. Write responses carry zero data.
- R11: Counters wrap from all ones to zero with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low cold reset |
| core_tick | input | 1 | Core cycle event |
| ref_tick | input | 1 | Constant-rate reference event |
| inst_ret | input | 1 | Instruction retired pulse |
| llc_stall | input | 1 | Dispatch stall due to last-level cache miss |
| wait_state | input | 1 | Core in a low-power wait state |
| aux_ev | input | 16 | Auxiliary event pulses, bit n feeds counter n |
| arch_en | input | 1 | Fixed group enable |
| aux_en | input | 1 | Auxiliary group enable |
| user_acc_en | input | 1 | Allows privilege-0 reads |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_grp | input | 1 | 0 = fixed group, 1 = auxiliary group |
| req_idx | input | 4 | Counter index within the group |
| req_wdata | input | CNT_W | Write data |
| req_priv | input | 2 | Requester privilege, 0 lowest |
| req_guest | input | 1 | Request comes from a guest |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | CNT_W | Read data |
| rsp_trap | output | 1 | Access trapped to the next privilege level |
| rsp_undef | output | 1 | Undefined-access response |

## Verification
A table of counting runs drives each fixed event alone, then every event except the one being read, to tell apart the index-to-event mapping. The same runs are repeated with the wait state held and with the group disabled, so that gating separates from mapping. The auxiliary vectors cover the first and last implemented slots, a neighbour's pulse, and an index past AUX_N whose low bits match a real slot, to expose aliasing. Directed cases restore a counter while its event is high, which shows whether the write or the increment wins. Other directed cases wrap a counter from all ones and sweep the guest and privilege combinations, with a follow-up read each time to confirm that nothing changed.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int ARCH_N = 4;
  localparam int SLOT_N = 16;
  localparam int IDX_W  = 4;
  localparam int PRIV_W = 2;

  typedef enum logic {
    GRP_ARCH = 1'b0,
    GRP_AUX  = 1'b1
  } grp_e;
endpackage

// File: rtl/actmon_counter.sv
module actmon_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/actmon_access.sv
module actmon_access
  import actmon_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              req_guest,
  input  logic              user_acc_en,
  output logic              grant_rd,
  output logic              grant_wr,
  output logic              deny_trap,
  output logic              deny_undef
);
  logic low_priv;

  always_comb begin
    low_priv   = (req_priv == '0);
    deny_undef = req_guest;
    deny_trap  = !req_guest && low_priv && (!user_acc_en || req_write);
    grant_rd   = req_valid && !req_write && !deny_undef && !deny_trap;
    grant_wr   = req_valid &&  req_write && !deny_undef && !deny_trap;
  end
endmodule

// File: rtl/actmon_bank.sv
module actmon_bank
  import actmon_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int AUX_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_tick,
  input  logic              ref_tick,
  input  logic              inst_ret,
  input  logic              llc_stall,
  input  logic              wait_state,
  input  logic [SLOT_N-1:0] aux_ev,
  input  logic              arch_en,
  input  logic              aux_en,
  input  logic              user_acc_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_grp,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [CNT_W-1:0]  req_wdata,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              req_guest,
  output logic              rsp_valid,
  output logic [CNT_W-1:0]  rsp_rdata,
  output logic              rsp_trap,
  output logic              rsp_undef
);
  logic [ARCH_N-1:0] arch_ev;
  logic [CNT_W-1:0]  arch_cnt [ARCH_N];
  logic [CNT_W-1:0]  aux_cnt  [SLOT_N];
  logic              grant_rd, grant_wr, deny_trap, deny_undef;
  logic [CNT_W-1:0]  rd_val;
  logic              run;

  assign arch_ev = {llc_stall, inst_ret, ref_tick, core_tick};
  assign run     = !wait_state;

  actmon_access u_acc (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_priv   (req_priv),
    .req_guest  (req_guest),
    .user_acc_en(user_acc_en),
    .grant_rd   (grant_rd),
    .grant_wr   (grant_wr),
    .deny_trap  (deny_trap),
    .deny_undef (deny_undef)
  );

  for (genvar g = 0; g < ARCH_N; g++) begin : g_arch
    logic ld;
    assign ld = grant_wr && (req_grp == GRP_ARCH) && (req_idx == IDX_W'(g));
    actmon_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (arch_ev[g] && arch_en && run),
      .ld    (ld),
      .ld_val(req_wdata),
      .cnt   (arch_cnt[g])
    );
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_aux
    if (g < AUX_N) begin : g_impl
      logic ld;
      assign ld = grant_wr && (req_grp == GRP_AUX) && (req_idx == IDX_W'(g));
      actmon_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (aux_ev[g] && aux_en && run),
        .ld    (ld),
        .ld_val(req_wdata),
        .cnt   (aux_cnt[g])
      );
    end else begin : g_empty
      logic unused_ev;
      assign unused_ev  = aux_ev[g];
      assign aux_cnt[g] = '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (req_grp == GRP_ARCH) begin
      if (arch_en && (int'(req_idx) < ARCH_N)) rd_val = arch_cnt[req_idx[1:0]];
    end else begin
      if (aux_en && (int'(req_idx) < AUX_N)) rd_val = aux_cnt[req_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_trap  <= 1'b0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= grant_rd ? rd_val : '0;
      rsp_trap  <= req_valid && deny_trap;
      rsp_undef <= req_valid && deny_undef;
    end
  end
endmodule

// File: rtl/actmon_bank_chk.sv
module actmon_bank_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_guest,
  input logic [1:0]       req_priv,
  input logic             user_acc_en,
  input logic             wait_state,
  input logic             rsp_valid,
  input logic             rsp_trap,
  input logic             rsp_undef,
  input logic [CNT_W-1:0] rsp_rdata,
  input logic [CNT_W-1:0] core_cnt
);
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_guest_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_guest |=> rsp_undef && !rsp_trap && (rsp_rdata == '0));

  p_user_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_guest && (req_priv == 2'd0) && (!user_acc_en || req_write)
    |=> rsp_trap && (rsp_rdata == '0));

  p_wait_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_state && !(req_valid && req_write) |=> $stable(core_cnt));
endmodule

bind actmon_bank actmon_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_guest  (req_guest),
  .req_priv   (req_priv),
  .user_acc_en(user_acc_en),
  .wait_state (wait_state),
  .rsp_valid  (rsp_valid),
  .rsp_trap   (rsp_trap),
  .rsp_undef  (rsp_undef),
  .rsp_rdata  (rsp_rdata),
  .core_cnt   (arch_cnt[0])
);

// File: tb/actmon_bank_test.sv
module actmon_bank_test;
  localparam int W = 64;
  localparam int NV = 13;

  typedef struct packed {
    logic        grp;
    logic [3:0]  idx;
    logic [3:0]  aev;
    logic [15:0] xev;
    logic        wt;
    logic        en;
    logic [7:0]  n;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{1'b0, 4'd0, 4'b0001, 16'h0000, 1'b0, 1'b1, 8'd5, 64'd5},
    '{1'b0, 4'd1, 4'b0010, 16'h0000, 1'b0, 1'b1, 8'd7, 64'd7},
    '{1'b0, 4'd2, 4'b0100, 16'h0000, 1'b0, 1'b1, 8'd3, 64'd3},
    '{1'b0, 4'd3, 4'b1000, 16'h0000, 1'b0, 1'b1, 8'd4, 64'd4},
    '{1'b0, 4'd0, 4'b1110, 16'hFFFF, 1'b0, 1'b1, 8'd6, 64'd0},
    '{1'b0, 4'd0, 4'b0001, 16'h0000, 1'b1, 1'b1, 8'd5, 64'd0},
    '{1'b0, 4'd2, 4'b0100, 16'h0000, 1'b0, 1'b0, 8'd5, 64'd0},
    '{1'b1, 4'd0, 4'b0000, 16'h0001, 1'b0, 1'b1, 8'd5, 64'd5},
    '{1'b1, 4'd3, 4'b0000, 16'h0008, 1'b0, 1'b1, 8'd9, 64'd9},
    '{1'b1, 4'd1, 4'b1111, 16'h0001, 1'b0, 1'b1, 8'd4, 64'd0},
    '{1'b1, 4'd2, 4'b0000, 16'hFFFF, 1'b0, 1'b0, 8'd6, 64'd0},
    '{1'b1, 4'd5, 4'b0000, 16'h0020, 1'b0, 1'b1, 8'd3, 64'd0},
    '{1'b0, 4'd7, 4'b1111, 16'h0000, 1'b0, 1'b1, 8'd3, 64'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_tick = 0, ref_tick = 0, inst_ret = 0, llc_stall = 0, wait_state = 0;
  logic [15:0] aux_ev = '0;
  logic arch_en = 1, aux_en = 1, user_acc_en = 0;
  logic req_valid = 0, req_write = 0, req_grp = 0, req_guest = 0;
  logic [3:0] req_idx = '0;
  logic [W-1:0] req_wdata = '0;
  logic [1:0] req_priv = 2'd1;
  logic rsp_valid, rsp_trap, rsp_undef;
  logic [W-1:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] r_data;
  logic r_trap, r_undef, r_valid;

  always #5 clk = ~clk;

  actmon_bank #(.CNT_W(W), .AUX_N(4)) uut (
    .clk(clk), .rst_n(rst_n), .core_tick(core_tick), .ref_tick(ref_tick),
    .inst_ret(inst_ret), .llc_stall(llc_stall), .wait_state(wait_state),
    .aux_ev(aux_ev), .arch_en(arch_en), .aux_en(aux_en), .user_acc_en(user_acc_en),
    .req_valid(req_valid), .req_write(req_write), .req_grp(req_grp),
    .req_idx(req_idx), .req_wdata(req_wdata), .req_priv(req_priv),
    .req_guest(req_guest), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_trap(rsp_trap), .rsp_undef(rsp_undef)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ev(input logic [3:0] a, input logic [15:0] x);
    {llc_stall, inst_ret, ref_tick, core_tick} = a;
    aux_ev = x;
  endtask

  // called at a negedge; returns at the negedge where the response is visible
  task automatic xfer(input logic wr, input logic g, input logic [3:0] i,
                      input logic [W-1:0] d, input logic [1:0] p, input logic gu);
    req_valid = 1; req_write = wr; req_grp = g; req_idx = i;
    req_wdata = d; req_priv = p; req_guest = gu;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0; req_guest = 0; req_priv = 2'd1;
    r_data = rsp_rdata; r_trap = rsp_trap; r_undef = rsp_undef; r_valid = rsp_valid;
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      xfer(0, 0, 4'(i), '0, 2'd1, 0);
      chk("R4 reset value", r_data, 64'd0);
    end
    @(negedge clk);
    chk("R10 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      xfer(1, VT[v].grp, VT[v].idx, '0, 2'd1, 0);
      wait_state = VT[v].wt; arch_en = VT[v].en; aux_en = VT[v].en;
      set_ev(VT[v].aev, VT[v].xev);
      repeat (int'(VT[v].n)) @(posedge clk);
      @(negedge clk);
      set_ev('0, '0); wait_state = 0; arch_en = 1; aux_en = 1;
      xfer(0, VT[v].grp, VT[v].idx, '0, 2'd1, 0);
      chk($sformatf("R1 R2 R3 R5 R9 vector %0d", v), r_data, VT[v].exp);
    end

    // R8 write and readback
    xfer(1, 0, 4'd1, 64'h1234_5678_9abc_def0, 2'd1, 0);
    xfer(0, 0, 4'd1, '0, 2'd1, 0);
    chk("R8 readback", r_data, 64'h1234_5678_9abc_def0);
    chk("R10 write response valid", {63'd0, r_valid}, 64'd1);

    // R8 write beats a same-cycle increment
    ref_tick = 1;
    xfer(1, 0, 4'd1, 64'd500, 2'd3, 0);
    ref_tick = 0;
    xfer(0, 0, 4'd1, '0, 2'd1, 0);
    chk("R8 write priority", r_data, 64'd500);

    // R11 wrap
    xfer(1, 0, 4'd0, {W{1'b1}}, 2'd1, 0);
    core_tick = 1;
    @(posedge clk);
    @(negedge clk);
    core_tick = 0;
    xfer(0, 0, 4'd0, '0, 2'd1, 0);
    chk("R11 wrap", r_data, 64'd0);

    // R5 write while disabled, read back after enable
    arch_en = 0;
    xfer(1, 0, 4'd2, 64'd42, 2'd1, 0);
    xfer(0, 0, 4'd2, '0, 2'd1, 0);
    chk("R5 disabled read", r_data, 64'd0);
    arch_en = 1;
    xfer(0, 0, 4'd2, '0, 2'd1, 0);
    chk("R5 restored value", r_data, 64'd42);

    // R6 guest
    xfer(1, 0, 4'd3, 64'd7, 2'd1, 0);
    xfer(1, 0, 4'd3, 64'd99, 2'd3, 1);
    chk("R6 write undef", {63'd0, r_undef}, 64'd1);
    chk("R6 write no trap", {63'd0, r_trap}, 64'd0);
    xfer(0, 0, 4'd3, '0, 2'd1, 1);
    chk("R6 read undef", {63'd0, r_undef}, 64'd1);
    chk("R6 read data", r_data, 64'd0);
    xfer(0, 0, 4'd3, '0, 2'd1, 0);
    chk("R6 unchanged", r_data, 64'd7);

    // R7 privilege 0
    user_acc_en = 0;
    xfer(0, 0, 4'd3, '0, 2'd0, 0);
    chk("R7 read trap", {63'd0, r_trap}, 64'd1);
    chk("R7 trap data", r_data, 64'd0);
    user_acc_en = 1;
    xfer(0, 0, 4'd3, '0, 2'd0, 0);
    chk("R7 allowed read trap", {63'd0, r_trap}, 64'd0);
    chk("R7 allowed read data", r_data, 64'd7);
    xfer(1, 0, 4'd3, 64'd55, 2'd0, 0);
    chk("R7 user write trap", {63'd0, r_trap}, 64'd1);
    xfer(0, 0, 4'd3, '0, 2'd1, 0);
    chk("R7 user write ignored", r_data, 64'd7);
    user_acc_en = 0;

    // R9 no aliasing on an unimplemented auxiliary index
    xfer(1, 1, 4'd1, 64'd11, 2'd1, 0);
    xfer(1, 1, 4'd5, 64'd77, 2'd1, 0);
    xfer(0, 1, 4'd1, '0, 2'd1, 0);
    chk("R9 aux alias", r_data, 64'd11);
    xfer(0, 1, 4'd5, '0, 2'd1, 0);
    chk("R9 aux unimplemented", r_data, 64'd0);
    xfer(1, 0, 4'd6, 64'd33, 2'd1, 0);
    xfer(0, 0, 4'd2, '0, 2'd1, 0);
    chk("R9 arch alias", r_data, 64'd42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule